// File: doc/BRIEF.md
# Dual-Write Register File with Standby and Conflict Flagging

This block is a small register array with two write ports and one read port. Both write ports commit on the rising clock edge. The read port is combinational: the read data follows the read address with no clock in the path. The block does not arbitrate between ports. When two enabled ports point at the same word in the same cycle, it raises a conflict flag. It then treats the result as unusable: the read data becomes unknown and every write involved leaves an unknown value in the word.

Two standby inputs reduce switching activity. Write standby freezes both write addresses and both write data buses at the values they held in the last cycle before standby began. The write enables and the clock keep working. Read standby freezes the read address in the same way. A timing monitor models a read access time of TACC cycles. It raises a flag when the effective read address moves before the previous address has been held that long.

Top module: `dual_write_regfile`

## Requirements
- R1: On a rising edge, each write port whose enable is high stores its data at its effective address. Two enabled ports with different addresses both store on the same edge.
- R2: The read data equals the stored word at the effective read address, combinationally and within the same cycle. It does not depend on the read enable.
- R3: With both write enables high and equal effective write addresses, the conflict output is high in that cycle, and the addressed word holds an unknown value after the edge.
- R4: With the read enable and a write enable high and equal effective read and write addresses, the conflict output is high in that cycle. The read data is unknown, and the written word holds an unknown value after the edge.
- R5: The conflict output is low in every cycle that meets neither the R3 nor the R4 condition.
- R6: While the write standby input is high, both effective write addresses and both effective write data values equal the live values sampled at the last edge at which write standby was low (zero if no such edge since reset). Writes still occur on enabled edges, using those held values.
- R7: While the read standby input is high, the effective read address equals the live read address sampled at the last edge at which read standby was low (zero if none since reset).
- R8: The read violation output is high for the cycle after an edge exactly when, at that edge, the effective read address differs from its value at the previous edge, and the previous address was seen at fewer than TACC consecutive edges.
- R9: During and after reset, both flags are low, and all held values and the previous read address are zero. The first read address change after reset never counts as a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; write ports commit on its rising edge |
| rstN | input | 1 | Active-low synchronous reset of control and hold state |
| wrStandby | input | 1 | Holds both write addresses and write data at their last values |
| rdStandby | input | 1 | Holds the read address at its last value |
| wrEn0 | input | 1 | Write port 0 enable |
| wrAddr0 | input | AW | Write port 0 address |
| wrData0 | input | DW | Write port 0 data |
| wrEn1 | input | 1 | Write port 1 enable |
| wrAddr1 | input | AW | Write port 1 address |
| wrData1 | input | DW | Write port 1 data |
| rdEn | input | 1 | Read port enable, used for conflict detection |
| rdAddr | input | AW | Read address |
| rdData | output | DW | Combinational read data |
| conflict | output | 1 | High in any cycle with a same-address port conflict |
| readViolation | output | 1 | High for one cycle after a read address change that came too early |

## Verification
On every cycle, the assertions check that a same-address condition between enabled ports raises the conflict flag. They also check that the flag is never raised with both write enables low, that held addresses do not move while a standby input stays high, and that a read violation never follows an edge taken in read standby. The bench scenarios cover the rest. These include both ports storing on one edge, a write under standby landing on the held address with the held data, reads that keep their old address under read standby, and the read-timing window on both sides of TACC. A reference model of the array and the hold registers covers the randomized traffic.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Strobes from control to datapath, one set per clock cycle.
  typedef struct packed {
    logic wrStb0;   // port 0 commits at the next edge
    logic wrStb1;   // port 1 commits at the next edge
    logic poison0;  // port 0 commit stores an unknown value
    logic poison1;  // port 1 commit stores an unknown value
    logic rdBlank;  // read data is invalid this cycle
  } rfStrobes_t;

endpackage

// File: rtl/rf_input_hold.sv
module rf_input_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  logic [WIDTH-1:0] live,
  output logic [WIDTH-1:0] eff
);

  logic [WIDTH-1:0] heldQ;

  // Capture only outside standby; during standby the last capture is used.
  always_ff @(posedge clk) begin
    if (!rstN)         heldQ <= '0;
    else if (!standby) heldQ <= live;
  end

  assign eff = standby ? heldQ : live;

endmodule

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
#(
  parameter int AW   = 5,
  parameter int TACC = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn0,
  input  logic          wrEn1,
  input  logic          rdEn,
  input  logic [AW-1:0] effA0,
  input  logic [AW-1:0] effA1,
  input  logic [AW-1:0] effR,
  output rfStrobes_t    strb,
  output logic          conflict,
  output logic          readViolation
);

  localparam int CW = $clog2(TACC + 1);
  localparam logic [CW-1:0] HOLD_MAX = CW'(TACC);

  logic wwHit, rw0Hit, rw1Hit;
  logic [AW-1:0] lastRdAddr;
  logic [CW-1:0] holdCnt;
  logic rdMoved;

  // Same-address detection between enabled ports.
  always_comb begin
    wwHit  = wrEn0 && wrEn1 && (effA0 == effA1);
    rw0Hit = rdEn && wrEn0 && (effR == effA0);
    rw1Hit = rdEn && wrEn1 && (effR == effA1);
    conflict = wwHit || rw0Hit || rw1Hit;

    strb.wrStb0  = wrEn0;
    strb.wrStb1  = wrEn1;
    strb.poison0 = wrEn0 && (wwHit || rw0Hit);
    strb.poison1 = wrEn1 && (wwHit || rw1Hit);
    strb.rdBlank = rw0Hit || rw1Hit;
  end

  // Read access window: count the edges for which the current address has been held.
  assign rdMoved = (effR != lastRdAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRdAddr    <= '0;
      holdCnt       <= HOLD_MAX;
      readViolation <= 1'b0;
    end else begin
      lastRdAddr <= effR;
      if (rdMoved) begin
        readViolation <= (holdCnt < HOLD_MAX);
        holdCnt       <= CW'(1);
      end else begin
        readViolation <= 1'b0;
        if (holdCnt != HOLD_MAX) holdCnt <= holdCnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/rf_array.sv
module rf_array
  import rf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  rfStrobes_t    strb,
  input  logic [AW-1:0] effA0,
  input  logic [DW-1:0] effD0,
  input  logic [AW-1:0] effA1,
  input  logic [DW-1:0] effD1,
  input  logic [AW-1:0] effR,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] mem [DEPTH];

  // Port 1 is applied after port 0; on equal addresses both are poisoned anyway.
  always_ff @(posedge clk) begin
    if (strb.wrStb0) mem[effA0] <= strb.poison0 ? {DW{1'bx}} : effD0;
    if (strb.wrStb1) mem[effA1] <= strb.poison1 ? {DW{1'bx}} : effD1;
  end

  assign rdData = strb.rdBlank ? {DW{1'bx}} : mem[effR];

endmodule

// File: rtl/dual_write_regfile.sv
module dual_write_regfile
  import rf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int TACC  = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrStandby,
  input  logic          rdStandby,
  input  logic          wrEn0,
  input  logic [AW-1:0] wrAddr0,
  input  logic [DW-1:0] wrData0,
  input  logic          wrEn1,
  input  logic [AW-1:0] wrAddr1,
  input  logic [DW-1:0] wrData1,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic          conflict,
  output logic          readViolation
);

  localparam int NWP = 2;

  logic [AW-1:0] liveWrAddr [NWP];
  logic [DW-1:0] liveWrData [NWP];
  logic [AW-1:0] effWrAddr  [NWP];
  logic [DW-1:0] effWrData  [NWP];
  logic [AW-1:0] effRdAddr;
  rfStrobes_t    strb;

  assign liveWrAddr[0] = wrAddr0;
  assign liveWrAddr[1] = wrAddr1;
  assign liveWrData[0] = wrData0;
  assign liveWrData[1] = wrData1;

  for (genvar gp = 0; gp < NWP; gp++) begin : g_wrHold
    rf_input_hold #(.WIDTH(AW)) u_addrHold (
      .clk(clk), .rstN(rstN), .standby(wrStandby),
      .live(liveWrAddr[gp]), .eff(effWrAddr[gp])
    );
    rf_input_hold #(.WIDTH(DW)) u_dataHold (
      .clk(clk), .rstN(rstN), .standby(wrStandby),
      .live(liveWrData[gp]), .eff(effWrData[gp])
    );
  end

  rf_input_hold #(.WIDTH(AW)) u_rdHold (
    .clk(clk), .rstN(rstN), .standby(rdStandby),
    .live(rdAddr), .eff(effRdAddr)
  );

  rf_ctrl #(.AW(AW), .TACC(TACC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn0(wrEn0), .wrEn1(wrEn1), .rdEn(rdEn),
    .effA0(effWrAddr[0]), .effA1(effWrAddr[1]), .effR(effRdAddr),
    .strb(strb), .conflict(conflict), .readViolation(readViolation)
  );

  rf_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_array (
    .clk(clk), .strb(strb),
    .effA0(effWrAddr[0]), .effD0(effWrData[0]),
    .effA1(effWrAddr[1]), .effD1(effWrData[1]),
    .effR(effRdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/dual_write_regfile_chk.sv
module dual_write_regfile_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrStandby,
  input logic          rdStandby,
  input logic          wrEn0,
  input logic          wrEn1,
  input logic          rdEn,
  input logic [AW-1:0] effA0,
  input logic [AW-1:0] effA1,
  input logic [AW-1:0] effR,
  input logic          conflict,
  input logic          readViolation
);

  assert_ww_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn0 && wrEn1 && effA0 == effA1) |-> conflict);

  assert_rw_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && ((wrEn0 && effR == effA0) || (wrEn1 && effR == effA1))) |-> conflict);

  assert_no_flag_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn0 && !wrEn1) |-> !conflict);

  assert_wr_freeze_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrStandby && $past(wrStandby)) |-> ($stable(effA0) && $stable(effA1)));

  assert_rd_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStandby && $past(rdStandby)) |-> $stable(effR));

  assert_viol_not_standby_R8: assert property (@(posedge clk) disable iff (!rstN)
    readViolation |-> !$past(rdStandby));

endmodule

bind dual_write_regfile dual_write_regfile_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .wrStandby(wrStandby), .rdStandby(rdStandby),
  .wrEn0(wrEn0), .wrEn1(wrEn1), .rdEn(rdEn),
  .effA0(effWrAddr[0]), .effA1(effWrAddr[1]), .effR(effRdAddr),
  .conflict(conflict), .readViolation(readViolation)
);

// File: tb/dual_write_regfile_tb.sv
module dual_write_regfile_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int DW    = 16;
  localparam int TACC  = 3;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN, wrStandby, rdStandby, wrEn0, wrEn1, rdEn;
  logic [AW-1:0] wrAddr0, wrAddr1, rdAddr;
  logic [DW-1:0] wrData0, wrData1;
  logic [DW-1:0] rdData;
  logic conflict, readViolation;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] mMem [DEPTH];
  bit            mValid [DEPTH];
  logic [AW-1:0] hA0, hA1, hR, mLast;
  logic [DW-1:0] hD0, hD1;
  int            mHold;
  bit            mViol;
  logic [AW-1:0] eA0, eA1, eR;
  logic [DW-1:0] eD0, eD1;
  bit            xWW, xRW0, xRW1;
  logic [DW-1:0] sampledRd;
  logic          sampledCf;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_write_regfile #(.DEPTH(DEPTH), .DW(DW), .TACC(TACC)) u_dut (
    .clk(clk), .rstN(rstN), .wrStandby(wrStandby), .rdStandby(rdStandby),
    .wrEn0(wrEn0), .wrAddr0(wrAddr0), .wrData0(wrData0),
    .wrEn1(wrEn1), .wrAddr1(wrAddr1), .wrData1(wrData1),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .conflict(conflict), .readViolation(readViolation)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit rdConflictExp();
    return xRW0 || xRW1;
  endfunction

  // Called just after a falling edge, once inputs are set. Returns after the next falling edge.
  task automatic step(input bit checkRead = 1);
    #1;
    eA0 = wrStandby ? hA0 : wrAddr0;
    eA1 = wrStandby ? hA1 : wrAddr1;
    eD0 = wrStandby ? hD0 : wrData0;
    eD1 = wrStandby ? hD1 : wrData1;
    eR  = rdStandby ? hR  : rdAddr;
    xWW  = wrEn0 && wrEn1 && (eA0 == eA1);
    xRW0 = rdEn && wrEn0 && (eR == eA0);
    xRW1 = rdEn && wrEn1 && (eR == eA1);
    sampledRd = rdData;
    sampledCf = conflict;
    if (xWW)
      check(conflict === 1'b1, "R3", 32'(conflict), 32'd1);
    else if (xRW0 || xRW1)
      check(conflict === 1'b1, "R4", 32'(conflict), 32'd1);
    else
      check(conflict === 1'b0, "R5", 32'(conflict), 32'd0);
    if (checkRead && !rdConflictExp() && mValid[eR])
      check(rdData === mMem[eR], "R2", 32'(rdData), 32'(mMem[eR]));
    @(posedge clk);
    if (wrEn0) begin
      if (xWW || xRW0) mValid[eA0] = 0;
      else begin mMem[eA0] = eD0; mValid[eA0] = 1; end
    end
    if (wrEn1) begin
      if (xWW || xRW1) mValid[eA1] = 0;
      else begin mMem[eA1] = eD1; mValid[eA1] = 1; end
    end
    if (eR != mLast) begin
      mViol = (mHold < TACC);
      mHold = 1;
    end else begin
      mViol = 0;
      if (mHold < TACC) mHold++;
    end
    mLast = eR;
    if (!wrStandby) begin hA0 = wrAddr0; hA1 = wrAddr1; hD0 = wrData0; hD1 = wrData1; end
    if (!rdStandby) hR = rdAddr;
    @(negedge clk);
    check(readViolation === mViol, "R8", 32'(readViolation), 32'(mViol));
  endtask

  task automatic idle();
    wrEn0 = 0; wrEn1 = 0; rdEn = 0; wrStandby = 0; rdStandby = 0;
  endtask

  // Hold the read address long enough that the next change is legal.
  task automatic settleRead(input logic [AW-1:0] a);
    idle(); rdAddr = a;
    for (int i = 0; i < TACC + 1; i++) step();
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4711);
    rstN = 0; idle();
    wrAddr0 = '0; wrAddr1 = '0; rdAddr = '0; wrData0 = '0; wrData1 = '0;
    for (int i = 0; i < DEPTH; i++) begin mValid[i] = 0; mMem[i] = '0; end
    hA0 = '0; hA1 = '0; hR = '0; hD0 = '0; hD1 = '0; mLast = '0; mHold = TACC; mViol = 0;
    repeat (3) @(negedge clk);
    check(conflict === 1'b0, "R9", 32'(conflict), 32'd0);
    check(readViolation === 1'b0, "R9", 32'(readViolation), 32'd0);
    rstN = 1;

    // R9: first read address change after reset is not a violation
    rdAddr = 5'd7; step();
    check(readViolation === 1'b0, "R9", 32'(readViolation), 32'd0);
    settleRead(5'd7);

    // R1: both ports store on one edge at different addresses
    wrEn0 = 1; wrAddr0 = 5'd5; wrData0 = 16'hAAAA;
    wrEn1 = 1; wrAddr1 = 5'd6; wrData1 = 16'h5555;
    step();
    idle(); rdAddr = 5'd5; step();
    check(sampledRd === 16'hAAAA, "R1", 32'(sampledRd), 32'hAAAA);
    settleRead(5'd6);
    check(sampledRd === 16'h5555, "R1", 32'(sampledRd), 32'h5555);

    // R6: write under standby uses held address and data
    wrEn0 = 1; wrAddr0 = 5'd10; wrData0 = 16'h3333; step();
    idle(); wrAddr0 = 5'd9; wrData0 = 16'h1111; step();
    wrStandby = 1; wrEn0 = 1; wrAddr0 = 5'd10; wrData0 = 16'h2222; step();
    settleRead(5'd9);
    check(sampledRd === 16'h1111, "R6", 32'(sampledRd), 32'h1111);
    settleRead(5'd10);
    check(sampledRd === 16'h3333, "R6", 32'(sampledRd), 32'h3333);

    // R7: read standby keeps the old address
    settleRead(5'd5);
    rdStandby = 1; rdAddr = 5'd6; step();
    check(sampledRd === 16'hAAAA, "R7", 32'(sampledRd), 32'hAAAA);
    check(readViolation === 1'b0, "R7", 32'(readViolation), 32'd0);

    // R3: write/write on the same address
    idle(); wrEn0 = 1; wrEn1 = 1; wrAddr0 = 5'd12; wrAddr1 = 5'd12; step();
    check(sampledCf === 1'b1, "R3", 32'(sampledCf), 32'd1);
    // R4: read/write on the same address
    idle(); rdEn = 1; rdAddr = 5'd5; wrEn1 = 1; wrAddr1 = 5'd5; step(0);
    check(sampledCf === 1'b1, "R4", 32'(sampledCf), 32'd1);
    // R5: enables high but addresses differ
    settleRead(5'd20);
    rdEn = 1; wrEn0 = 1; wrAddr0 = 5'd21; wrEn1 = 1; wrAddr1 = 5'd22; step();
    check(sampledCf === 1'b0, "R5", 32'(sampledCf), 32'd0);

    // R8: boundary of the read access window
    settleRead(5'd1);
    rdAddr = 5'd2; for (int i = 0; i < TACC - 1; i++) step();
    rdAddr = 5'd3; step();
    check(readViolation === 1'b1, "R8", 32'(readViolation), 32'd1);
    settleRead(5'd3);
    rdAddr = 5'd4; for (int i = 0; i < TACC; i++) step();
    rdAddr = 5'd8; step();
    check(readViolation === 1'b0, "R8", 32'(readViolation), 32'd0);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      wrEn0 = ($urandom % 3) == 0;
      wrEn1 = ($urandom % 3) == 0;
      rdEn  = ($urandom % 2) == 0;
      wrAddr0 = AW'(($urandom % 4 == 0) ? $urandom : $urandom % 8);
      wrAddr1 = AW'(($urandom % 4 == 0) ? $urandom : $urandom % 8);
      wrData0 = DW'($urandom);
      wrData1 = DW'($urandom);
      if ($urandom % 3 == 0) rdAddr = AW'($urandom % 8);
      wrStandby = ($urandom % 8) == 0;
      rdStandby = ($urandom % 8) == 0;
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule